// File: doc/BRIEF.md
# Two-Pool Frame Receive Buffer

This block sits between a serial frame deframer and a host processor on one receive channel. The deframer hands over one byte per cycle together with end-of-frame, CRC, validity and abort indications. The block keeps the bytes in two 32-byte pools and tells the host about them with two events. The pool-full event fires when a programmable number of bytes of a frame that is still arriving can be read. The message-end event fires when the frame has ended.

For a frame that ends, the host reads the stored bytes and then one more entry: a status byte. The frame status is also kept in a register, together with the full frame length as a high and a low byte. A pool is never reclaimed by reading it. The host frees the oldest signalled pool with a one-cycle release command. If the host falls behind and both pools are taken, the rest of the incoming frame is dropped. Its status then carries an overflow flag, and it is delivered as soon as a pool comes free.

The input side has valid only: a deframer cannot be stalled, so there is no back-pressure and bytes that find no room are dropped. The read side is valid/ready. An entry is consumed on a cycle where both are high. While ready is low, the presented entry and its data stay put.

Top module: `rxpool_buffer`

## Requirements
- R1: The 2-bit threshold select sets the chunk size: 00 gives 32 bytes (the pool size), 01 gives 16, 10 gives 4 and 11 gives 2.
- R2: When a frame that has not ended has a threshold's worth of stored bytes in its current chunk, `irq_pool_full` fires and that chunk holds exactly the threshold number of data bytes.
- R3: When the last byte of a frame is accepted, `irq_msg_end` fires. The chunk holds the remaining data bytes (at most the threshold) followed by one status entry, which is marked by `rd_is_status`. A frame of exactly the threshold length raises only the message-end event.
- R4: The status byte has bit 0 = CRC good, bit 1 = frame valid, bit 2 = abort seen, bit 3 = overflow, and bits 7:4 = 0. The same value is loaded into `rx_stat` at every message-end event.
- R5: At every message-end event, `len_hi`/`len_lo` are loaded with the number of bytes the frame delivered at the input, counting dropped bytes. `len_hi` holds bits 15:8 and `len_lo` holds bits 7:0.
- R6: A pool is freed only by `host_rmc`. Once a chunk has been fully read, `rd_valid` stays low until the release. A release with no signalled chunk outstanding has no effect.
- R7: Chunks are read and released strictly in the order they were signalled, and each release frees the oldest one.
- R8: A byte that arrives while the next pool is still held by the host is dropped, and so is the rest of its frame. That frame's end is reported with the overflow bit set and a chunk of zero data bytes, as soon as a pool is released.
- R9: After reset, no event is raised, `rd_valid` is low, and `len_hi`, `len_lo` and `rx_stat` are zero.
- R10: While `rd_valid` is high and `rd_ready` is low, with no release, `rd_valid` stays high and `rd_data` does not change.
- R11: Each event is a single-cycle pulse per signalled chunk, and the two events are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thresh | input | 2 | Chunk size select (R1 encoding) |
| in_valid | input | 1 | Deframer byte valid (no back-pressure) |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_ok | input | 1 | CRC good, sampled with the last byte |
| in_frame_ok | input | 1 | Frame valid, sampled with the last byte |
| in_abort | input | 1 | Abort seen, sampled with the last byte |
| rd_valid | output | 1 | A readable entry is presented |
| rd_ready | input | 1 | Host accepts the presented entry |
| rd_data | output | 8 | Data byte or status byte |
| rd_is_status | output | 1 | Presented entry is the frame status byte |
| host_rmc | input | 1 | Release the oldest signalled pool |
| irq_pool_full | output | 1 | Threshold chunk ready, frame still running |
| irq_msg_end | output | 1 | Frame ended, final chunk ready |
| len_hi | output | 8 | Frame length, upper byte |
| len_lo | output | 8 | Frame length, lower byte |
| rx_stat | output | 8 | Status of the last ended frame |

## Verification
The assertions check, on every cycle, that:
- the two events never coincide;
- a status entry is only presented while valid, with its upper nibble clear;
- a stalled read entry holds steady;
- nothing is readable when no chunk is outstanding, where the count of outstanding chunks is rebuilt from the events and the releases;
- that count never exceeds the number of pools.

Only the directed scenarios can show the rest:
- the byte values and the chunk boundaries that each threshold setting produces;
- the status and length contents;
- the order in which chunks come back;
- the delayed delivery of an overflowed frame once the host releases a pool.

// File: rtl/rxpool_pkg.sv
package rxpool_pkg;

  // Per-frame flags, packed so that crc lands in bit 0 and ovf in bit 3.
  typedef struct packed {
    logic ovf;
    logic abort;
    logic valid;
    logic crc;
  } rx_flags_t;

  localparam int unsigned STAT_W = 8;

  function automatic logic [STAT_W-1:0] stat_byte(input rx_flags_t f);
    return {4'b0000, f};
  endfunction

  // Threshold select to byte count; the largest setting equals one pool.
  function automatic int unsigned thr_bytes(input logic [1:0] sel, input int unsigned pool_bytes);
    case (sel)
      2'b00:   return pool_bytes;
      2'b01:   return pool_bytes / 2;
      2'b10:   return 4;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/rxpool_wr.sv
module rxpool_wr
  import rxpool_pkg::*;
#(
  parameter int unsigned POOLS      = 2,
  parameter int unsigned POOL_BYTES = 32,
  parameter int unsigned LEN_W      = 16,
  localparam int unsigned PW        = (POOLS > 1) ? $clog2(POOLS) : 1,
  localparam int unsigned CW        = $clog2(POOL_BYTES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       thr_sel,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_crc_ok,
  input  logic             in_frame_ok,
  input  logic             in_abort,
  input  logic [POOLS-1:0] busy,
  output logic             wr_en,
  output logic [PW-1:0]    wr_pool,
  output logic [CW-1:0]    wr_idx,
  output logic [7:0]       wr_data,
  output logic             cm_valid,
  output logic             cm_end,
  output logic [CW-1:0]    cm_len,
  output rx_flags_t        cm_flags,
  output logic [LEN_W-1:0] cm_flen
);

  logic [PW-1:0]    pool_q;
  logic [CW-1:0]    cnt_q;
  logic [LEN_W-1:0] flen_q;
  logic             drop_q;
  logic             pend_q;
  rx_flags_t        pend_fl_q;
  logic [LEN_W-1:0] pend_len_q;

  logic [CW-1:0] thr;
  logic [CW-1:0] cnt_inc;
  logic          pool_free;
  logic          store;
  logic          pend_go;
  logic          pend_set;
  rx_flags_t     end_fl;

  assign thr       = CW'(thr_bytes(thr_sel, POOL_BYTES));
  assign cnt_inc   = cnt_q + 1'b1;
  assign pool_free = !busy[pool_q];
  assign store     = in_valid && !pend_q && !drop_q && pool_free;
  assign pend_go   = pend_q && pool_free;
  assign pend_set  = in_valid && !pend_q && !store && in_last && !pool_free;

  always_comb begin
    end_fl       = '0;
    end_fl.crc   = in_crc_ok;
    end_fl.valid = in_frame_ok;
    end_fl.abort = in_abort;
    end_fl.ovf   = !store;
  end

  always_comb begin
    cm_valid = 1'b0;
    cm_end   = 1'b0;
    cm_len   = cnt_inc;
    cm_flags = end_fl;
    cm_flen  = flen_q + 1'b1;
    if (pend_go) begin
      cm_valid = 1'b1;
      cm_end   = 1'b1;
      cm_len   = '0;
      cm_flags = pend_fl_q;
      cm_flen  = pend_len_q;
    end else if (store && (in_last || cnt_inc >= thr)) begin
      cm_valid = 1'b1;
      cm_end   = in_last;
    end else if (in_valid && !pend_q && !store && in_last && pool_free) begin
      // dropped frame ends while a pool is free: status-only chunk
      cm_valid = 1'b1;
      cm_end   = 1'b1;
      cm_len   = cnt_q;
    end
  end

  assign wr_en   = store;
  assign wr_pool = pool_q;
  assign wr_idx  = cnt_q;
  assign wr_data = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_q     <= '0;
      cnt_q      <= '0;
      flen_q     <= '0;
      drop_q     <= 1'b0;
      pend_q     <= 1'b0;
      pend_fl_q  <= '0;
      pend_len_q <= '0;
    end else begin
      if (cm_valid) begin
        pool_q <= (pool_q == PW'(POOLS - 1)) ? '0 : pool_q + 1'b1;
        cnt_q  <= '0;
      end else if (store) begin
        cnt_q <= cnt_inc;
      end
      if (in_valid) begin
        flen_q <= in_last ? '0 : flen_q + 1'b1;
        if (in_last)     drop_q <= 1'b0;
        else if (!store) drop_q <= 1'b1;
      end
      if (pend_go) begin
        pend_q <= 1'b0;
      end else if (pend_set) begin
        pend_q     <= 1'b1;
        pend_fl_q  <= end_fl;
        pend_len_q <= flen_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxpool_store.sv
module rxpool_store
  import rxpool_pkg::*;
#(
  parameter int unsigned POOLS      = 2,
  parameter int unsigned POOL_BYTES = 32,
  localparam int unsigned PW        = (POOLS > 1) ? $clog2(POOLS) : 1,
  localparam int unsigned CW        = $clog2(POOL_BYTES + 2),
  localparam int unsigned AW        = $clog2(POOL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_pool,
  input  logic [CW-1:0]    wr_idx,
  input  logic [7:0]       wr_data,
  input  logic             cm_valid,
  input  logic             cm_end,
  input  logic [CW-1:0]    cm_len,
  input  rx_flags_t        cm_flags,
  input  logic             rel_valid,
  input  logic [PW-1:0]    rel_pool,
  input  logic [PW-1:0]    rd_pool,
  input  logic [CW-1:0]    rd_idx,
  output logic [POOLS-1:0] busy,
  output logic [CW-1:0]    rd_len,
  output logic             rd_end,
  output logic [7:0]       rd_byte
);

  logic [7:0]        mem    [POOLS][POOL_BYTES];
  logic [CW-1:0]     len_q  [POOLS];
  logic [STAT_W-1:0] stat_q [POOLS];
  logic [POOLS-1:0]  end_q;
  logic [POOLS-1:0]  busy_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_pool][wr_idx[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      end_q  <= '0;
      for (int p = 0; p < POOLS; p++) begin
        len_q[p]  <= '0;
        stat_q[p] <= '0;
      end
    end else begin
      for (int p = 0; p < POOLS; p++) begin
        if (cm_valid && wr_pool == PW'(p)) begin
          busy_q[p] <= 1'b1;
          end_q[p]  <= cm_end;
          len_q[p]  <= cm_len;
          stat_q[p] <= stat_byte(cm_flags);
        end else if (rel_valid && rel_pool == PW'(p)) begin
          busy_q[p] <= 1'b0;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign rd_len  = len_q[rd_pool];
  assign rd_end  = end_q[rd_pool];
  assign rd_byte = (rd_end && rd_idx == rd_len) ? stat_q[rd_pool]
                                                : mem[rd_pool][rd_idx[AW-1:0]];

endmodule

// File: rtl/rxpool_rd.sv
module rxpool_rd #(
  parameter int unsigned POOLS      = 2,
  parameter int unsigned POOL_BYTES = 32,
  localparam int unsigned PW        = (POOLS > 1) ? $clog2(POOLS) : 1,
  localparam int unsigned CW        = $clog2(POOL_BYTES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POOLS-1:0] busy,
  input  logic [CW-1:0]    rd_len,
  input  logic             rd_end,
  input  logic             rd_ready,
  input  logic             host_rmc,
  output logic [PW-1:0]    rd_pool,
  output logic [CW-1:0]    rd_idx,
  output logic             rd_valid,
  output logic             rd_is_status,
  output logic             rel_valid,
  output logic [PW-1:0]    rel_pool
);

  logic [PW-1:0] pool_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] limit;

  assign limit        = rd_len + CW'(rd_end);
  assign rd_valid     = busy[pool_q] && (idx_q < limit);
  assign rd_is_status = rd_valid && rd_end && (idx_q == rd_len);
  assign rel_valid    = host_rmc && busy[pool_q];
  assign rel_pool     = pool_q;
  assign rd_pool      = pool_q;
  assign rd_idx       = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_q <= '0;
      idx_q  <= '0;
    end else if (rel_valid) begin
      pool_q <= (pool_q == PW'(POOLS - 1)) ? '0 : pool_q + 1'b1;
      idx_q  <= '0;
    end else if (rd_valid && rd_ready) begin
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/rxpool_buffer.sv
module rxpool_buffer
  import rxpool_pkg::*;
#(
  parameter int unsigned POOLS      = 2,
  parameter int unsigned POOL_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_thresh,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_crc_ok,
  input  logic       in_frame_ok,
  input  logic       in_abort,
  output logic       rd_valid,
  input  logic       rd_ready,
  output logic [7:0] rd_data,
  output logic       rd_is_status,
  input  logic       host_rmc,
  output logic       irq_pool_full,
  output logic       irq_msg_end,
  output logic [7:0] len_hi,
  output logic [7:0] len_lo,
  output logic [7:0] rx_stat
);

  localparam int unsigned LEN_W = 16;
  localparam int unsigned PW    = (POOLS > 1) ? $clog2(POOLS) : 1;
  localparam int unsigned CW    = $clog2(POOL_BYTES + 2);

  logic             wr_en;
  logic [PW-1:0]    wr_pool;
  logic [CW-1:0]    wr_idx;
  logic [7:0]       wr_data;
  logic             cm_valid;
  logic             cm_end;
  logic [CW-1:0]    cm_len;
  rx_flags_t        cm_flags;
  logic [LEN_W-1:0] cm_flen;
  logic [POOLS-1:0] busy;
  logic [CW-1:0]    rd_len;
  logic             rd_end;
  logic [PW-1:0]    rd_pool;
  logic [CW-1:0]    rd_idx;
  logic             rel_valid;
  logic [PW-1:0]    rel_pool;

  logic             pf_q;
  logic             me_q;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       stat_q;

  rxpool_wr #(.POOLS(POOLS), .POOL_BYTES(POOL_BYTES), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .thr_sel(cfg_thresh),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_ok(in_crc_ok), .in_frame_ok(in_frame_ok), .in_abort(in_abort),
    .busy(busy), .wr_en(wr_en), .wr_pool(wr_pool), .wr_idx(wr_idx), .wr_data(wr_data),
    .cm_valid(cm_valid), .cm_end(cm_end), .cm_len(cm_len),
    .cm_flags(cm_flags), .cm_flen(cm_flen)
  );

  rxpool_store #(.POOLS(POOLS), .POOL_BYTES(POOL_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_pool(wr_pool), .wr_idx(wr_idx), .wr_data(wr_data),
    .cm_valid(cm_valid), .cm_end(cm_end), .cm_len(cm_len), .cm_flags(cm_flags),
    .rel_valid(rel_valid), .rel_pool(rel_pool), .rd_pool(rd_pool), .rd_idx(rd_idx),
    .busy(busy), .rd_len(rd_len), .rd_end(rd_end), .rd_byte(rd_data)
  );

  rxpool_rd #(.POOLS(POOLS), .POOL_BYTES(POOL_BYTES)) u_rd (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_len(rd_len), .rd_end(rd_end),
    .rd_ready(rd_ready), .host_rmc(host_rmc), .rd_pool(rd_pool), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_is_status(rd_is_status),
    .rel_valid(rel_valid), .rel_pool(rel_pool)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q   <= 1'b0;
      me_q   <= 1'b0;
      len_q  <= '0;
      stat_q <= '0;
    end else begin
      pf_q <= cm_valid && !cm_end;
      me_q <= cm_valid && cm_end;
      if (cm_valid && cm_end) begin
        len_q  <= cm_flen;
        stat_q <= stat_byte(cm_flags);
      end
    end
  end

  assign irq_pool_full = pf_q;
  assign irq_msg_end   = me_q;
  assign len_hi        = len_q[15:8];
  assign len_lo        = len_q[7:0];
  assign rx_stat       = stat_q;

endmodule

// File: rtl/rxpool_buffer_chk.sv
module rxpool_buffer_chk #(
  parameter int unsigned POOLS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       rd_is_status,
  input logic       host_rmc,
  input logic       irq_pool_full,
  input logic       irq_msg_end
);

  // Outstanding signalled chunks, rebuilt from events and releases only.
  logic [4:0] outst_q;
  logic [4:0] eff;

  assign eff = outst_q + {4'b0000, (irq_pool_full || irq_msg_end)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= eff - {4'b0000, (host_rmc && eff != 5'd0)};
  end

  a_r11_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pool_full && irq_msg_end));

  a_r4_status_form: assert property (@(posedge clk) disable iff (!rst_n)
    rd_is_status |-> (rd_valid && rd_data[7:4] == 4'h0));

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !host_rmc) |=> (rd_valid && $stable(rd_data)));

  a_r6_nothing_unsignalled: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == 5'd0) |-> !rd_valid);

  a_r8_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    eff <= 5'(POOLS));

endmodule

bind rxpool_buffer rxpool_buffer_chk #(.POOLS(POOLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_is_status(rd_is_status), .host_rmc(host_rmc),
  .irq_pool_full(irq_pool_full), .irq_msg_end(irq_msg_end)
);

// File: tb/rxpool_buffer_bench.sv
module rxpool_buffer_bench;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_thresh = 2'b00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_crc_ok = 1'b0;
  logic       in_frame_ok = 1'b0;
  logic       in_abort = 1'b0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_is_status;
  logic       host_rmc = 1'b0;
  logic       irq_pool_full;
  logic       irq_msg_end;
  logic [7:0] len_hi;
  logic [7:0] len_lo;
  logic [7:0] rx_stat;

  int n_vec = 0;
  int n_bad = 0;
  int n_pf  = 0;
  int n_me  = 0;

  rxpool_buffer u_rxpool_buffer (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_ok(in_crc_ok), .in_frame_ok(in_frame_ok), .in_abort(in_abort),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_is_status(rd_is_status), .host_rmc(host_rmc),
    .irq_pool_full(irq_pool_full), .irq_msg_end(irq_msg_end),
    .len_hi(len_hi), .len_lo(len_lo), .rx_stat(rx_stat)
  );

  always #(CLK_NS / 2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (irq_pool_full) n_pf++;
      if (irq_msg_end)   n_me++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] base,
                            input logic crc, input logic fok, input logic ab);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_data     = base + 8'(i);
      in_last     = (i == n - 1);
      in_crc_ok   = crc;
      in_frame_ok = fok;
      in_abort    = ab;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic read_chunk(input int n, input logic [7:0] base, input logic has_stat,
                            input logic [7:0] exp_stat, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({req, " data valid"}, int'(rd_valid), 1);
      chk({req, " data byte"}, int'(rd_data), int'(base + 8'(i)));
      chk({req, " not status"}, int'(rd_is_status), 0);
      rd_ready = 1'b1;
    end
    if (has_stat) begin
      @(negedge clk);
      chk({req, " status valid"}, int'(rd_valid), 1);
      chk({req, " status flag"}, int'(rd_is_status), 1);
      chk({req, " status byte"}, int'(rd_data), int'(exp_stat));
      rd_ready = 1'b1;
    end
    @(negedge clk);
    rd_ready = 1'b0;
    chk("R6 drained chunk stays empty until release", int'(rd_valid), 0);
  endtask

  task automatic release_pool();
    host_rmc = 1'b1;
    @(negedge clk);
    host_rmc = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 rd_valid after reset", int'(rd_valid), 0);
    chk("R9 irq_pool_full after reset", int'(irq_pool_full), 0);
    chk("R9 irq_msg_end after reset", int'(irq_msg_end), 0);
    chk("R9 length after reset", int'({len_hi, len_lo}), 0);
    chk("R9 status after reset", int'(rx_stat), 0);
  endtask

  task automatic t_short_frame();
    int pf0 = n_pf;
    int me0 = n_me;
    cfg_thresh = 2'b00;
    send_frame(10, 8'h10, 1'b1, 1'b1, 1'b0);
    idle(2);
    chk("R3 one message-end for short frame", n_me - me0, 1);
    chk("R2 no pool-full for short frame", n_pf - pf0, 0);
    chk("R5 length low", int'(len_lo), 10);
    chk("R5 length high", int'(len_hi), 0);
    chk("R4 status register good frame", int'(rx_stat), 8'h03);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 stalled entry valid", int'(rd_valid), 1);
      chk("R10 stalled entry data", int'(rd_data), 8'h10);
    end
    read_chunk(10, 8'h10, 1'b1, 8'h03, "R3 short frame");
    release_pool();
  endtask

  task automatic t_split_16();
    int pf0 = n_pf;
    int me0 = n_me;
    cfg_thresh = 2'b01;
    send_frame(20, 8'h40, 1'b1, 1'b1, 1'b0);
    idle(2);
    chk("R1 R11 one pool-full at 16 bytes", n_pf - pf0, 1);
    chk("R11 one message-end", n_me - me0, 1);
    read_chunk(16, 8'h40, 1'b0, 8'h00, "R2 first chunk of 16");
    release_pool();
    read_chunk(4, 8'h50, 1'b1, 8'h03, "R7 tail chunk");
    release_pool();
    chk("R5 length of split frame", int'({len_hi, len_lo}), 20);
  endtask

  task automatic t_small_thresholds();
    int pf0 = n_pf;
    int me0 = n_me;
    cfg_thresh = 2'b10;
    send_frame(4, 8'h60, 1'b0, 1'b1, 1'b0);
    idle(2);
    chk("R3 exact threshold gives no pool-full", n_pf - pf0, 0);
    chk("R3 exact threshold message-end", n_me - me0, 1);
    chk("R4 status register crc bad", int'(rx_stat), 8'h02);
    read_chunk(4, 8'h60, 1'b1, 8'h02, "R1 threshold 4");
    release_pool();
    cfg_thresh = 2'b11;
    pf0 = n_pf;
    me0 = n_me;
    send_frame(3, 8'h70, 1'b1, 1'b1, 1'b0);
    idle(2);
    chk("R1 threshold 2 pool-full", n_pf - pf0, 1);
    chk("R1 threshold 2 message-end", n_me - me0, 1);
    read_chunk(2, 8'h70, 1'b0, 8'h00, "R2 threshold 2 chunk");
    release_pool();
    read_chunk(1, 8'h72, 1'b1, 8'h03, "R3 threshold 2 tail");
    release_pool();
  endtask

  task automatic t_overflow();
    int pf0 = n_pf;
    int me0 = n_me;
    cfg_thresh = 2'b11;
    send_frame(7, 8'h80, 1'b1, 1'b1, 1'b0);
    idle(3);
    chk("R8 two chunks signalled before overflow", n_pf - pf0, 2);
    chk("R6 overflowed end held until release", n_me - me0, 0);
    read_chunk(2, 8'h80, 1'b0, 8'h00, "R7 oldest chunk first");
    release_pool();
    idle(3);
    chk("R8 end delivered after release", n_me - me0, 1);
    chk("R8 overflow status register", int'(rx_stat), 8'h0B);
    chk("R8 length counts dropped bytes", int'({len_hi, len_lo}), 7);
    read_chunk(2, 8'h82, 1'b0, 8'h00, "R7 second chunk");
    release_pool();
    read_chunk(0, 8'h00, 1'b1, 8'h0B, "R8 status-only chunk");
    release_pool();
  endtask

  task automatic t_empty_release_and_order();
    release_pool();
    release_pool();
    idle(1);
    chk("R6 release with nothing signalled", int'(rd_valid), 0);
    cfg_thresh = 2'b00;
    send_frame(3, 8'hA0, 1'b0, 1'b0, 1'b1);
    send_frame(2, 8'hC0, 1'b1, 1'b1, 1'b0);
    idle(2);
    chk("R5 length of latest frame", int'({len_hi, len_lo}), 2);
    chk("R4 status register latest frame", int'(rx_stat), 8'h03);
    read_chunk(3, 8'hA0, 1'b1, 8'h04, "R6 stray release ignored, abort status");
    release_pool();
    read_chunk(2, 8'hC0, 1'b1, 8'h03, "R7 second frame after first");
    release_pool();
    idle(1);
    chk("R6 all released", int'(rd_valid), 0);
  endtask

  bit done = 1'b0;

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_short_frame();
    t_split_16();
    t_small_thresholds();
    t_overflow();
    t_empty_release_and_order();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule